// File: doc/BRIEF.md
# USB Device Event and Status Reporter

This block sits between a USB protocol engine and the application logic of a device. The engine raises single-cycle event strobes when a transaction step finishes: an 8-byte SETUP stage is complete, isochronous data came in with the DATA1 PID, or a valid SOF, IN or OUT token was seen. The engine also shows which receive FIFOs hold data, and whether a bus reset is in progress. The block turns these inputs into two kinds of outputs. Sticky flags stay set until the application clears them. Token pulses last exactly two USB bit times.

A second SETUP can complete while the first one has not yet been acknowledged. In that case a separate flag records it, and the first flag is left as it is. Bit time is given by a one-cycle bit-clock enable input. The application reads the flags and clears them through an 8-bit register port. That port has a write/read select (high means write) and an active-low strobe.

Top module: `usb_evt_reporter`

## Requirements
- R1: A cycle of `ev_setup_done` while `setup_flag` is low sets `setup_flag` on the next clock. It stays set until it is cleared.
- R2: A cycle of `ev_setup_done` while `setup_flag` is high, with no clear of it in that cycle, sets `setup_again` and leaves `setup_flag` high.
- R3: After a token event (`ev_sof`, `ev_in`, `ev_out`), the matching pulse output stays low until the next `bit_en` cycle. It goes high on the clock of that cycle and stays high for exactly two `bit_en` periods, falling on the clock of the second `bit_en` cycle that follows. The other two pulse outputs are not affected.
- R4: `pkt_ready[i]` sets on the clock after `fifo_valid[i]` is high. Writing bit 4+i of the clear register clears it only while `fifo_valid[i]` is low. Otherwise the write has no effect.
- R5: A cycle of `ev_iso_data1` sets `iso_pid_err` on the next clock. It stays set until it is cleared.
- R6: A read is `reg_stb_n`=0 with `reg_wr`=0. A read of address 0x00 returns status with bit0=`setup_flag`, bit1=`setup_again`, bit2=`iso_pid_err`, bit3=0 and bits 7:4=`pkt_ready`. Any other address, and no strobe, give 0x00.
- R7: A write is `reg_stb_n`=0 with `reg_wr`=1. A write to address 0x01 clears each flag whose status bit position holds a 1, on the next clock, and leaves the other flags alone. A write to another address, or with the strobe high, changes nothing.
- R8: A set event in the same cycle as a clear of the same flag leaves the flag set.
- R9: `bus_rst` follows `bus_rst_det` one clock later.
- R10: While `ctl_rst` is high, every flag and pulse output is low. All of them stay low after release until an event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ctl_rst | input | 1 | Active-high controller reset |
| bit_en | input | 1 | One-cycle enable per USB bit time |
| ev_setup_done | input | 1 | 8-byte SETUP stage complete |
| ev_iso_data1 | input | 1 | Isochronous data came with DATA1 PID |
| ev_sof | input | 1 | Valid SOF token seen |
| ev_in | input | 1 | Valid IN token seen |
| ev_out | input | 1 | Valid OUT token seen |
| fifo_valid | input | 4 | Receive FIFO holds data, one bit per FIFO |
| bus_rst_det | input | 1 | Bus reset detected by the engine |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_stb_n | input | 1 | Active-low transfer strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| setup_flag | output | 1 | SETUP received |
| setup_again | output | 1 | Second SETUP while first unacknowledged |
| iso_pid_err | output | 1 | Isochronous DATA1 error |
| pkt_ready | output | 4 | Per-FIFO packet ready |
| sof_pulse | output | 1 | Two-bit-time SOF pulse |
| in_pulse | output | 1 | Two-bit-time IN pulse |
| out_pulse | output | 1 | Two-bit-time OUT pulse |
| bus_rst | output | 1 | Bus reset to the application |

## Verification
A flag bank in the wrong state shows on its own output pin on the first clock after the event. It also shows in the status byte on the first read that follows. A SETUP routed to the wrong flag, or a clear that hits the wrong bit, is therefore visible in one cycle. A pulse counter that loads or counts wrongly shows as a pulse that starts early, or that is still high (or already low) after the second bit-enable. The pulse is sampled between bit-enables, so a one-period error is seen within a single bit time.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int N_FIFO = 4;
  localparam logic [ADDR_W-1:0] REG_STATUS = 8'h00;
  localparam logic [ADDR_W-1:0] REG_CLEAR  = 8'h01;
  localparam int PKT_LSB = 4;

  typedef struct packed {
    logic [N_FIFO-1:0] pkt;
    logic              iso;
    logic              setup2;
    logic              setup;
  } flag_vec_t;
endpackage

// File: rtl/usb_evt_stretch.sv
module usb_evt_stretch #(
  parameter int PULSE_BITS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic trig,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PULSE_BITS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_BITS);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (bit_en) begin
      if (armed_q) begin
        cnt_d   = LOAD;
        armed_d = 1'b0;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (trig) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = (cnt_q != '0);

  // R3: the pulse edges only follow a bit-enable cycle
  a_r3_edge_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(pulse_o));
  // R3: the counter never goes past its load value
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD);
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
  import usb_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_setup,
  input  logic              ev_iso,
  input  logic [N_FIFO-1:0] fifo_valid,
  input  flag_vec_t         clr,
  output flag_vec_t         flags
);
  flag_vec_t f_q, f_d;

  always_comb begin
    f_d = f_q;
    if (clr.setup)  f_d.setup  = 1'b0;
    if (clr.setup2) f_d.setup2 = 1'b0;
    if (clr.iso)    f_d.iso    = 1'b0;
    for (int i = 0; i < N_FIFO; i++) begin
      if (clr.pkt[i] && !fifo_valid[i]) f_d.pkt[i] = 1'b0;
      if (fifo_valid[i])                f_d.pkt[i] = 1'b1;
    end
    if (ev_setup) begin
      if (f_q.setup && !clr.setup) f_d.setup2 = 1'b1;
      else                         f_d.setup  = 1'b1;
    end
    if (ev_iso) f_d.iso = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  assign flags = f_q;

  a_r1_setup_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup && !f_q.setup |=> f_q.setup);
  a_r2_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_setup && f_q.setup && !clr.setup |=> f_q.setup && f_q.setup2);
  a_r5_iso_set: assert property (@(posedge clk) disable iff (!rst_n)
    ev_iso |=> f_q.iso);

  for (genvar g = 0; g < N_FIFO; g++) begin : g_pkt_chk
    // R4: a FIFO with data keeps its ready bit
    a_r4_pkt_held: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_valid[g] |=> f_q.pkt[g]);
  end
endmodule

// File: rtl/usb_evt_regport.sv
module usb_evt_regport
  import usb_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_stb_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  flag_vec_t         flags,
  output flag_vec_t         clr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic wr_hit, rd_hit;
  logic [DATA_W-1:0] status;

  assign wr_hit = !reg_stb_n && reg_wr && (reg_addr == REG_CLEAR);
  assign rd_hit = !reg_stb_n && !reg_wr && (reg_addr == REG_STATUS);

  always_comb begin
    status = '0;
    status[0] = flags.setup;
    status[1] = flags.setup2;
    status[2] = flags.iso;
    status[PKT_LSB +: N_FIFO] = flags.pkt;
  end

  always_comb begin
    clr = '0;
    if (wr_hit) begin
      clr.setup  = reg_wdata[0];
      clr.setup2 = reg_wdata[1];
      clr.iso    = reg_wdata[2];
      clr.pkt    = reg_wdata[PKT_LSB +: N_FIFO];
    end
  end

  assign reg_rdata = rd_hit ? status : '0;

  a_r7_read_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> clr == '0);
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_stb_n |-> reg_rdata == '0);
endmodule

// File: rtl/usb_evt_reporter.sv
module usb_evt_reporter
  import usb_evt_pkg::*;
#(
  parameter int PULSE_BITS = 2
) (
  input  logic              clk,
  input  logic              ctl_rst,
  input  logic              bit_en,
  input  logic              ev_setup_done,
  input  logic              ev_iso_data1,
  input  logic              ev_sof,
  input  logic              ev_in,
  input  logic              ev_out,
  input  logic [N_FIFO-1:0] fifo_valid,
  input  logic              bus_rst_det,
  input  logic              reg_wr,
  input  logic              reg_stb_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              setup_flag,
  output logic              setup_again,
  output logic              iso_pid_err,
  output logic [N_FIFO-1:0] pkt_ready,
  output logic              sof_pulse,
  output logic              in_pulse,
  output logic              out_pulse,
  output logic              bus_rst
);
  localparam int N_TOK = 3;

  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or posedge ctl_rst) begin
    if (ctl_rst) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [N_TOK-1:0] tok_trig, tok_pulse;
  assign tok_trig = {ev_out, ev_in, ev_sof};

  for (genvar t = 0; t < N_TOK; t++) begin : g_tok
    usb_evt_stretch #(.PULSE_BITS(PULSE_BITS)) u_str (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .trig    (tok_trig[t]),
      .pulse_o (tok_pulse[t])
    );
  end
  assign sof_pulse = tok_pulse[0];
  assign in_pulse  = tok_pulse[1];
  assign out_pulse = tok_pulse[2];

  flag_vec_t flags, clr;

  usb_evt_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_setup   (ev_setup_done),
    .ev_iso     (ev_iso_data1),
    .fifo_valid (fifo_valid),
    .clr        (clr),
    .flags      (flags)
  );

  usb_evt_regport u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_stb_n (reg_stb_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flags),
    .clr       (clr),
    .reg_rdata (reg_rdata)
  );

  assign setup_flag  = flags.setup;
  assign setup_again = flags.setup2;
  assign iso_pid_err = flags.iso;
  assign pkt_ready   = flags.pkt;

  logic bus_rst_q, bus_rst_d;
  always_comb bus_rst_d = bus_rst_det;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rst_q <= 1'b0;
    else        bus_rst_q <= bus_rst_d;
  end
  assign bus_rst = bus_rst_q;

  a_r9_bus_rst_follow: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_det |=> bus_rst);
endmodule

// File: tb/usb_evt_reporter_tb.sv
module usb_evt_reporter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       ctl_rst, bit_en, ev_setup_done, ev_iso_data1, ev_sof, ev_in, ev_out;
  logic [3:0] fifo_valid;
  logic       bus_rst_det, reg_wr, reg_stb_n;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       setup_flag, setup_again, iso_pid_err, sof_pulse, in_pulse, out_pulse, bus_rst;
  logic [3:0] pkt_ready;

  usb_evt_reporter u_dut (
    .clk(clk), .ctl_rst(ctl_rst), .bit_en(bit_en), .ev_setup_done(ev_setup_done),
    .ev_iso_data1(ev_iso_data1), .ev_sof(ev_sof), .ev_in(ev_in), .ev_out(ev_out),
    .fifo_valid(fifo_valid), .bus_rst_det(bus_rst_det), .reg_wr(reg_wr),
    .reg_stb_n(reg_stb_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .setup_flag(setup_flag), .setup_again(setup_again),
    .iso_pid_err(iso_pid_err), .pkt_ready(pkt_ready), .sof_pulse(sof_pulse),
    .in_pulse(in_pulse), .out_pulse(out_pulse), .bus_rst(bus_rst)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) nxt();
  endtask

  // one cycle of events and an optional register write
  task automatic drive1(input logic s, input logic iso, input logic sf, input logic ti,
                        input logic to, input logic do_wr, input logic [7:0] a,
                        input logic [7:0] d);
    nxt();
    ev_setup_done = s; ev_iso_data1 = iso; ev_sof = sf; ev_in = ti; ev_out = to;
    if (do_wr) begin
      reg_stb_n = 1'b0; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    end
    nxt();
    ev_setup_done = 0; ev_iso_data1 = 0; ev_sof = 0; ev_in = 0; ev_out = 0;
    reg_stb_n = 1'b1; reg_wr = 1'b0;
  endtask

  task automatic wr_clr(input logic [7:0] a, input logic [7:0] d);
    drive1(0, 0, 0, 0, 0, 1, a, d);
  endtask

  // driver: queue the expected read value, then perform the read
  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    nxt();
    reg_stb_n = 1'b0; reg_wr = 1'b0; reg_addr = a;
    nxt();
    reg_stb_n = 1'b1;
  endtask

  task automatic bit_tick();
    nxt(); bit_en = 1'b1;
    nxt(); bit_en = 1'b0;
  endtask

  // monitor: compare every read against the scoreboard queue
  always @(negedge clk) begin
    #5;
    if (!reg_stb_n && !reg_wr && !ctl_rst) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 unexpected read actual=%h expected=none", reg_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, reg_rdata, e);
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic tok_test(input int which, input string tag);
    logic [2:0] sel, got;
    sel = 3'b001 << which;
    drive1(0, 0, sel[0], sel[1], sel[2], 0, 8'h00, 8'h00);
    got = {out_pulse, in_pulse, sof_pulse};
    chk({tag, " R3 idle before bit_en"}, {5'd0, got}, 8'h00);
    idle(3);
    got = {out_pulse, in_pulse, sof_pulse};
    chk({tag, " R3 still idle"}, {5'd0, got}, 8'h00);
    bit_tick();
    got = {out_pulse, in_pulse, sof_pulse};
    chk({tag, " R3 rise on bit_en, others low"}, {5'd0, got}, {5'd0, sel});
    idle(3);
    got = {out_pulse, in_pulse, sof_pulse};
    chk({tag, " R3 held mid period"}, {5'd0, got}, {5'd0, sel});
    bit_tick();
    got = {out_pulse, in_pulse, sof_pulse};
    chk({tag, " R3 held after one bit"}, {5'd0, got}, {5'd0, sel});
    bit_tick();
    got = {out_pulse, in_pulse, sof_pulse};
    chk({tag, " R3 fall after two bits"}, {5'd0, got}, 8'h00);
  endtask

  initial begin
    ctl_rst = 1; bit_en = 0; ev_setup_done = 0; ev_iso_data1 = 0;
    ev_sof = 0; ev_in = 0; ev_out = 0; fifo_valid = 4'h0; bus_rst_det = 0;
    reg_wr = 0; reg_stb_n = 1; reg_addr = 8'h00; reg_wdata = 8'h00;
    idle(3);
    chk("R10 flags in reset", {1'b0, setup_flag, setup_again, iso_pid_err, pkt_ready}, 8'h00);
    chk("R10 pulses in reset", {4'd0, sof_pulse, in_pulse, out_pulse, bus_rst}, 8'h00);
    ctl_rst = 0;
    idle(4);
    chk("R10 flags after release", {1'b0, setup_flag, setup_again, iso_pid_err, pkt_ready}, 8'h00);
    rd(8'h00, 8'h00, "R10 status after release");

    // R1 / R2
    drive1(1, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    chk("R1 setup_flag set", {6'd0, setup_flag, setup_again}, 8'h02);
    drive1(1, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    chk("R2 second setup kept first", {6'd0, setup_flag, setup_again}, 8'h03);
    rd(8'h00, 8'h03, "R6 status both setup");

    // R7 clearing
    wr_clr(8'h01, 8'h01);
    chk("R7 clear bit0 only", {6'd0, setup_flag, setup_again}, 8'h01);
    rd(8'h00, 8'h02, "R6 status setup_again only");
    wr_clr(8'h05, 8'h02);
    chk("R7 wrong address ignored", {7'd0, setup_again}, 8'h01);
    nxt(); reg_stb_n = 1; reg_wr = 1; reg_addr = 8'h01; reg_wdata = 8'h02;
    nxt(); reg_wr = 0;
    chk("R7 no strobe ignored", {7'd0, setup_again}, 8'h01);
    wr_clr(8'h01, 8'h02);
    chk("R7 clear bit1", {7'd0, setup_again}, 8'h00);

    // R5 / R8 iso
    drive1(0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
    chk("R5 iso error set", {7'd0, iso_pid_err}, 8'h01);
    rd(8'h00, 8'h04, "R6 status iso bit2");
    drive1(0, 1, 0, 0, 0, 1, 8'h01, 8'h04);
    chk("R8 iso set wins over clear", {7'd0, iso_pid_err}, 8'h01);
    wr_clr(8'h01, 8'h04);
    chk("R7 iso cleared", {7'd0, iso_pid_err}, 8'h00);

    // R8 setup
    drive1(1, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    drive1(1, 0, 0, 0, 0, 1, 8'h01, 8'h01);
    chk("R8 setup set wins over clear", {6'd0, setup_flag, setup_again}, 8'h02);
    wr_clr(8'h01, 8'h01);
    chk("R7 setup cleared", {6'd0, setup_flag, setup_again}, 8'h00);

    // R4 packet ready
    nxt(); fifo_valid = 4'b0100;
    nxt();
    chk("R4 pkt_ready set", {4'd0, pkt_ready}, 8'h04);
    rd(8'h00, 8'h40, "R6 status pkt bit6");
    wr_clr(8'h01, 8'h40);
    chk("R4 clear ignored while FIFO has data", {4'd0, pkt_ready}, 8'h04);
    nxt(); fifo_valid = 4'b0000;
    idle(2);
    chk("R4 sticky after drain", {4'd0, pkt_ready}, 8'h04);
    wr_clr(8'h01, 8'h40);
    chk("R4 cleared after drain", {4'd0, pkt_ready}, 8'h00);

    // R3 token pulses
    tok_test(0, "sof");
    tok_test(1, "in");
    tok_test(2, "out");

    // R9
    nxt(); bus_rst_det = 1;
    nxt();
    chk("R9 bus_rst follows", {7'd0, bus_rst}, 8'h01);
    bus_rst_det = 0;
    nxt();
    chk("R9 bus_rst released", {7'd0, bus_rst}, 8'h00);

    rd(8'h02, 8'h00, "R6 other address reads zero");
    idle(3);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R6 reads missing actual=%0d expected=0", exp_q.size());
    end
    summary();
  end
endmodule